// File: doc/BRIEF.md
# Staged Reset Sequencer

This block decides when each of several downstream modules may leave reset. It holds every module in reset until the clock manager reports lock, then frees the modules one at a time in a fixed order, stage 0 first. Each module answers with an acknowledge flag once its own state machine has passed through its initialization state. The sequencer moves on only when that flag has been seen low and then high again after the release.

The external reset pin does not reach any flip-flop reset. It is synchronized and filtered, and a request that lasts long enough sends the sequencer back to its start. Loss of lock does the same. A stage that does not acknowledge in time sets a sticky error bit and the whole sequence restarts. The lock input, the acknowledges and the external reset all pass through two-flop synchronizers. The reset outputs are registered, so every release happens on a clock edge. A separate power-on reset, `por_n`, initializes only the sequencer's own registers.

Top module: `staged_reset_ctrl`

## Requirements
- R1: While the lock input has not been seen high, all `mod_rst` bits are 1 (1 means held in reset). `mod_rst[0]` goes to 0 at the third rising edge after `clk_locked` rises, two edges for synchronization and one for the state machine.
- R2: Outputs are released in index order, 0 up to NUM_STAGES-1, one bit per step. The released bits always form a contiguous group starting at bit 0. Bit k+1 is not released until stage k has acknowledged.
- R3: After stage k is released, a level on `mod_ack[k]` that was already high is not accepted. The synchronized acknowledge must be seen low during the wait and then high before the next stage is released.
- R4: `sys_ready` is 1 only when every output is released. It rises at the third rising edge after the last stage's acknowledge rises at the input.
- R5: If `clk_locked` falls at any time, including while running, all outputs return to 1 and `sys_ready` to 0 at the third rising edge. The sequence starts again from stage 0 once lock returns.
- R6: `ext_rst_n` low for fewer than 4 synchronized cycles has no effect. When it is held low for 4 or more cycles, all outputs are 1 and `sys_ready` is 0 at the seventh rising edge after it falls. They stay that way while it remains low, and the sequence restarts after it rises.
- R7: If a stage waits 1024 cycles for its acknowledge without getting it, `stage_err[k]` for that stage goes to 1, all outputs return to 1, and the sequence restarts.
- R8: `stage_err` bits are sticky. A restart, a lock loss, an external reset or a later successful bring-up never clears them.
- R9: While `por_n` is low, `mod_rst` is all ones, `sys_ready` is 0 and `stage_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset of the sequencer's own registers, active low |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| clk_locked | input | 1 | Clock-manager lock indication, asynchronous |
| mod_ack | input | NUM_STAGES | Per-module acknowledge, high while the module is in its init state |
| mod_rst | output | NUM_STAGES | Per-module reset, 1 = held in reset |
| sys_ready | output | 1 | All modules released and acknowledged |
| stage_err | output | NUM_STAGES | Sticky per-stage acknowledge-timeout flags |

## Verification
The first bring-up uses prompt acknowledges, which shows the release order and the exact ready latency. A second bring-up starts with an acknowledge already high, which separates a design that checks the level only from one that requires a fresh low-to-high pass. External reset pulses of three cycles and of ten cycles test the hold filter from both sides. A lock drop while running and a stage that never answers test the two other restart paths, and the second of these also shows that the error bit survives later bring-ups.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_WAIT_LOCK = 3'd1,
    PH_RELEASE   = 3'd2,
    PH_WAIT_ACK  = 3'd3,
    PH_RUN       = 3'd4
  } phase_t;

  // True once the wait counter has covered `limit` cycles (counter starts at 0).
  function automatic logic wait_expired(input logic [31:0] cnt, input int unsigned limit);
    return cnt >= 32'(limit - 1);
  endfunction

  // Saturating step of the request hold counter.
  function automatic logic [31:0] hold_step(input logic [31:0] cnt, input logic req,
                                            input int unsigned limit);
    if (!req) return 32'd0;
    if (cnt >= 32'(limit)) return 32'(limit);
    return cnt + 32'd1;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   W       = 1,
  parameter int   DEPTH   = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg[i] <= {W{RST_VAL}};
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i - 1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/rstseq_hold_filter.sv
module rstseq_hold_filter
  import rstseq_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req_n_s,
  output logic hold_met
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else cnt_q <= CW'(hold_step(32'(cnt_q), !req_n_s, HOLD));
  end

  assign hold_met = (32'(cnt_q) == 32'(HOLD));
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int N       = 4,
  parameter int TIMEOUT = 1024
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         lock_s,
  input  logic         ext_hold,
  input  logic [N-1:0] ack_s,
  output logic [N-1:0] rst_out,
  output logic [N-1:0] err_out,
  output logic         ready_out,
  output logic         abort_lock,
  output logic         stage_done,
  output logic         tmo_hit
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int TMO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  phase_t           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             seen_low_q, seen_low_d;
  logic [N-1:0]     rst_q, rst_d;
  logic [N-1:0]     err_q, err_d;
  logic             ready_q;
  logic             cur_ack;
  logic             in_stage;

  assign cur_ack    = ack_s[idx_q];
  assign in_stage   = (phase_q == PH_RELEASE) || (phase_q == PH_WAIT_ACK) || (phase_q == PH_RUN);
  assign abort_lock = in_stage && !lock_s;
  assign stage_done = (phase_q == PH_WAIT_ACK) && seen_low_q && cur_ack;
  assign tmo_hit    = (phase_q == PH_WAIT_ACK) && !stage_done &&
                      wait_expired(32'(tmo_q), TIMEOUT);

  always_comb begin
    phase_d    = phase_q;
    idx_d      = idx_q;
    tmo_d      = tmo_q;
    seen_low_d = seen_low_q;
    rst_d      = rst_q;
    err_d      = err_q;
    if (ext_hold || abort_lock || tmo_hit) begin
      phase_d = PH_IDLE;
      idx_d   = '0;
      rst_d   = '1;
      if (tmo_hit) err_d[idx_q] = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          rst_d   = '1;
          phase_d = PH_WAIT_LOCK;
        end
        PH_WAIT_LOCK: begin
          if (lock_s) begin
            phase_d  = PH_RELEASE;
            idx_d    = '0;
            rst_d[0] = 1'b0;
          end
        end
        PH_RELEASE: begin
          phase_d    = PH_WAIT_ACK;
          tmo_d      = '0;
          seen_low_d = 1'b0;
        end
        PH_WAIT_ACK: begin
          tmo_d = tmo_q + TMO_W'(1);
          if (!cur_ack) seen_low_d = 1'b1;
          if (stage_done) begin
            if (idx_q == LAST) begin
              phase_d = PH_RUN;
            end else begin
              idx_d        = idx_q + IDX_W'(1);
              rst_d[idx_d] = 1'b0;
              phase_d      = PH_RELEASE;
            end
          end
        end
        PH_RUN: ;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q    <= PH_IDLE;
      idx_q      <= '0;
      tmo_q      <= '0;
      seen_low_q <= 1'b0;
      rst_q      <= '1;
      err_q      <= '0;
      ready_q    <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      idx_q      <= idx_d;
      tmo_q      <= tmo_d;
      seen_low_q <= seen_low_d;
      rst_q      <= rst_d;
      err_q      <= err_d;
      ready_q    <= (phase_d == PH_RUN);
    end
  end

  assign rst_out   = rst_q;
  assign err_out   = err_q;
  assign ready_out = ready_q;
endmodule

// File: rtl/staged_reset_ctrl.sv
module staged_reset_ctrl #(
  parameter int NUM_STAGES  = 4,
  parameter int SYNC_DEPTH  = 2,
  parameter int EXT_HOLD    = 4,
  parameter int ACK_TIMEOUT = 1024
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  ext_rst_n,
  input  logic                  clk_locked,
  input  logic [NUM_STAGES-1:0] mod_ack,
  output logic [NUM_STAGES-1:0] mod_rst,
  output logic                  sys_ready,
  output logic [NUM_STAGES-1:0] stage_err
);
  localparam int SW = NUM_STAGES + 1;

  logic [SW-1:0]         raw_vec, sync_vec;
  logic                  lock_s;
  logic [NUM_STAGES-1:0] ack_s;
  logic                  ext_n_s;
  logic                  ext_hold;
  logic                  abort_lock;
  logic                  stage_done;
  logic                  tmo_hit;

  assign raw_vec = {mod_ack, clk_locked};

  rstseq_sync #(.W(SW), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_in (
    .clk(clk), .arst_n(por_n), .d(raw_vec), .q(sync_vec)
  );

  assign lock_s = sync_vec[0];
  assign ack_s  = sync_vec[SW-1:1];

  rstseq_sync #(.W(1), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_ext (
    .clk(clk), .arst_n(por_n), .d(ext_rst_n), .q(ext_n_s)
  );

  rstseq_hold_filter #(.HOLD(EXT_HOLD)) u_filter (
    .clk(clk), .arst_n(por_n), .req_n_s(ext_n_s), .hold_met(ext_hold)
  );

  rstseq_fsm #(.N(NUM_STAGES), .TIMEOUT(ACK_TIMEOUT)) u_fsm (
    .clk(clk), .arst_n(por_n), .lock_s(lock_s), .ext_hold(ext_hold), .ack_s(ack_s),
    .rst_out(mod_rst), .err_out(stage_err), .ready_out(sys_ready),
    .abort_lock(abort_lock), .stage_done(stage_done), .tmo_hit(tmo_hit)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         por_n,
  input logic         lock_s,
  input logic         ext_hold,
  input logic [N-1:0] ack_s,
  input logic [N-1:0] mod_rst,
  input logic         sys_ready,
  input logic [N-1:0] stage_err,
  input logic         tmo_hit
);
  logic [N-1:0] freed;
  assign freed = ~mod_rst;

  AST_LOCK_HOLDS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !lock_s |=> (&mod_rst)); // R1
  AST_RELEASE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    (($past(mod_rst) & ~mod_rst) != '0) |-> $past(lock_s)); // R5
  AST_THERMO_ORDER: assert property (@(posedge clk) disable iff (!por_n)
    ((freed & (freed + N'(1))) == '0)); // R2
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!por_n)
    $countones($past(mod_rst) & ~mod_rst) <= 1); // R2
  AST_READY_ALL_FREE: assert property (@(posedge clk) disable iff (!por_n)
    sys_ready |-> (mod_rst == '0)); // R4
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_ready) |-> $past(ack_s[N-1])); // R4
  AST_EXT_RESETS_ALL: assert property (@(posedge clk) disable iff (!por_n)
    ext_hold |=> ((&mod_rst) && !sys_ready)); // R6
  AST_TIMEOUT_RESETS: assert property (@(posedge clk) disable iff (!por_n)
    tmo_hit |=> ((&mod_rst) && (stage_err != '0))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ((stage_err & $past(stage_err)) == $past(stage_err))); // R8
endmodule

bind staged_reset_ctrl rstseq_checker #(.N(NUM_STAGES)) u_chk (
  .clk(clk), .por_n(por_n), .lock_s(lock_s), .ext_hold(ext_hold), .ack_s(ack_s),
  .mod_rst(mod_rst), .sys_ready(sys_ready), .stage_err(stage_err), .tmo_hit(tmo_hit)
);

// File: tb/sim_staged_reset_ctrl.sv
module sim_staged_reset_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam logic [NS-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          por_n;
  logic          ext_rst_n;
  logic          clk_locked;
  logic [NS-1:0] mod_ack;
  logic [NS-1:0] mod_rst;
  logic          sys_ready;
  logic [NS-1:0] stage_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  staged_reset_ctrl u0 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .clk_locked(clk_locked),
    .mod_ack(mod_ack), .mod_rst(mod_rst), .sys_ready(sys_ready), .stage_err(stage_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Released bits 0..k: expected output pattern.
  function automatic logic [NS-1:0] exp_pattern(input int k);
    return ALL << (k + 1);
  endfunction

  task automatic wait_release(input int k, input string req);
    int n = 0;
    while (mod_rst[k] !== 1'b0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(mod_rst[k] === 1'b0, req, n, 60);
  endtask

  // Bring up stages first..last; acks of those stages start low.
  task automatic bring_up(input int first, input int last);
    for (int k = first; k <= last; k++) begin
      wait_release(k, "R2 release");
      chk(mod_rst == exp_pattern(k), "R2 order", int'(mod_rst), int'(exp_pattern(k)));
      repeat (4) @(negedge clk);
      chk(mod_rst == exp_pattern(k), "R2 no advance before ack", int'(mod_rst),
          int'(exp_pattern(k)));
      mod_ack[k] = 1'b1;
      if (k == NS - 1) begin
        edges(2);
        chk(sys_ready == 1'b0, "R4 ready latency early", int'(sys_ready), 0);
        edges(1);
        chk(sys_ready == 1'b1, "R4 ready latency", int'(sys_ready), 1);
        chk(mod_rst == '0, "R4 all released", int'(mod_rst), 0);
      end
    end
  endtask

  task automatic t_reset_state();
    por_n = 1'b0; ext_rst_n = 1'b1; clk_locked = 1'b0; mod_ack = '0;
    edges(4);
    chk(mod_rst == ALL, "R9 rst", int'(mod_rst), int'(ALL));
    chk(sys_ready == 1'b0, "R9 ready", int'(sys_ready), 0);
    chk(stage_err == '0, "R9 err", int'(stage_err), 0);
    @(negedge clk); por_n = 1'b1;
  endtask

  task automatic t_lock_gate();
    edges(40);
    chk(mod_rst == ALL, "R1 held without lock", int'(mod_rst), int'(ALL));
    @(negedge clk); clk_locked = 1'b1;
    edges(2);
    chk(mod_rst == ALL, "R1 lock sync delay", int'(mod_rst), int'(ALL));
    edges(1);
    chk(mod_rst == exp_pattern(0), "R1 first release", int'(mod_rst), int'(exp_pattern(0)));
  endtask

  task automatic t_ext_short();
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    edges(15);
    chk(sys_ready == 1'b1 && mod_rst == '0, "R6 short pulse ignored", int'(mod_rst), 0);
  endtask

  task automatic t_ext_long();
    @(negedge clk); ext_rst_n = 1'b0;
    edges(6);
    chk(sys_ready == 1'b1, "R6 hold not yet met", int'(sys_ready), 1);
    edges(1);
    chk(mod_rst == ALL && sys_ready == 1'b0, "R6 hold met", int'(mod_rst), int'(ALL));
    mod_ack = '0;
    edges(10);
    chk(mod_rst == ALL, "R6 held while low", int'(mod_rst), int'(ALL));
    @(negedge clk); ext_rst_n = 1'b1;
    bring_up(0, NS - 1);
  endtask

  task automatic t_lock_loss_and_stale();
    @(negedge clk); clk_locked = 1'b0;
    edges(2);
    chk(sys_ready == 1'b1, "R5 lock sync delay", int'(sys_ready), 1);
    edges(1);
    chk(mod_rst == ALL && sys_ready == 1'b0, "R5 lock loss", int'(mod_rst), int'(ALL));
    @(negedge clk);
    mod_ack = '0;
    mod_ack[0] = 1'b1;            // stale acknowledge for stage 0
    clk_locked = 1'b1;
    wait_release(0, "R5 restart");
    edges(30);
    chk(mod_rst[1] == 1'b1, "R3 stale ack rejected", int'(mod_rst), int'(exp_pattern(0)));
    @(negedge clk); mod_ack[0] = 1'b0;
    repeat (4) @(negedge clk);
    mod_ack[0] = 1'b1;
    wait_release(1, "R3 fresh ack accepted");
    bring_up(1, NS - 1);
  endtask

  task automatic t_timeout();
    @(negedge clk); clk_locked = 1'b0; mod_ack = '0;
    repeat (5) @(negedge clk);
    clk_locked = 1'b1;
    bring_up(0, 1);
    wait_release(2, "R7 stage 2 released");
    edges(900);
    chk(stage_err == '0 && mod_rst[3] == 1'b1, "R7 no early timeout", int'(stage_err), 0);
    @(negedge clk); mod_ack = '0;
    edges(200);
    chk(stage_err == 4'b0100, "R7 timeout flag", int'(stage_err), 4);
    chk(mod_rst[2] == 1'b1 && mod_rst[3] == 1'b1, "R7 outputs reasserted", int'(mod_rst), 12);
    bring_up(0, NS - 1);
    chk(stage_err == 4'b0100, "R8 sticky after bring-up", int'(stage_err), 4);
  endtask

  task automatic t_por_clear();
    @(negedge clk); por_n = 1'b0;
    edges(2);
    chk(stage_err == '0 && mod_rst == ALL && sys_ready == 1'b0, "R9 por clears",
        int'(stage_err), 0);
    @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_lock_gate();
    bring_up(0, NS - 1);
    t_ext_short();
    t_ext_long();
    t_lock_loss_and_stale();
    t_timeout();
    t_por_clear();
    finish_run();
  end
endmodule